// File: doc/BRIEF.md
# Buck Converter Mode Controller

This block decides, once per switching period, whether a synchronous buck controller runs in fixed-frequency PWM operation or in hysteretic light-load operation. At the moment low-side conduction ends, and just before the high-side switch turns on, a strobe marks when the phase-node comparator bit is valid. A low bit means the phase node is negative and inductor current flows forward. A high bit means the phase node is positive and current is reversing through the low-side switch.

The controller counts a run of consecutive samples that favour the other mode. It changes mode only when that run reaches a parameterised length, eight by default. This keeps the mode from chattering when the load sits near the boundary. On entry to hysteretic operation it raises a one-cycle request that turns off both switches. A load step, flagged by an output-undervoltage comparator, bypasses the run filter and returns the block to PWM on the next clock.

Top module: `buck_mode_ctrl`

## Requirements
- R1: After reset the block is in PWM mode (`hystMode` = 0), `bothOff` is 0, and the run counter is empty, so a full run of `RUN_LEN` qualifying samples is needed before any change.
- R2: In PWM mode, when `RUN_LEN` consecutive strobed samples have `phaseHigh` = 1, `hystMode` reads 1 after the clock edge that takes the last of them.
- R3: In hysteretic mode, when `RUN_LEN` consecutive strobed samples have `phaseHigh` = 0, `hystMode` reads 0 after the clock edge that takes the last of them.
- R4: A strobed sample of the opposite polarity (0 in PWM mode, 1 in hysteretic mode) empties the run counter, and a fresh full run is then required.
- R5: `phaseHigh` is ignored in cycles where `sampleStrobe` is 0. Such cycles neither extend nor break a run.
- R6: `bothOff` is 1 for exactly the first cycle in which `hystMode` reads 1 after a PWM-to-hysteretic change, and is 0 at all other times, including on a change back to PWM.
- R7: In hysteretic mode, `underVolt` = 1 makes `hystMode` read 0 after the next clock edge, whether or not a sample is strobed.
- R8: In PWM mode, `underVolt` has no effect on the mode or on the run counter.
- R9: The run counter empties on every mode change, so a run built up before an undervoltage exit does not count toward the next change.
- R10: When `underVolt` and the last sample of a completing run arrive in the same cycle in hysteretic mode, the block makes a single change to PWM and starts with an empty counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Switching-rate clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleStrobe | input | 1 | High for one cycle when low-side conduction ends |
| phaseHigh | input | 1 | Phase comparator: 1 means positive phase node |
| underVolt | input | 1 | 1 means output is below the hysteretic regulation level |
| hystMode | output | 1 | 1 means hysteretic mode, 0 means PWM mode |
| bothOff | output | 1 | One-cycle request to turn off both switches |

## Verification
The bench builds the block with the default `RUN_LEN` of 8. This makes the run boundary concrete: a run of seven must hold the mode and the eighth must flip it, in both directions. Because the length is short, the bench can break runs at several depths, pad strobes with idle cycles carrying misleading phase values, and line an undervoltage pulse up exactly with the eighth sample. It can also show that a partial run left over before an undervoltage exit does not shorten the next run.

// File: rtl/buck_mode_pkg.sv
package buck_mode_pkg;

  // Operating mode of the converter
  typedef enum logic {
    MODE_PWM  = 1'b0,
    MODE_HYST = 1'b1
  } opMode_e;

  // Strobes from the mode sequencer to the run counter
  typedef struct packed {
    logic countUp;
    logic countClear;
  } runStrobe_t;

endpackage

// File: rtl/mode_run_counter.sv
module mode_run_counter
  import buck_mode_pkg::*;
#(
  parameter int RUN_LEN = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  runStrobe_t                    strobes,
  output logic [$clog2(RUN_LEN)-1:0]    runCount,
  output logic                          runFull
);

  localparam int CNT_W = $clog2(RUN_LEN);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RUN_LEN - 1);

  // Length of the current run of samples favouring the other mode
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCount <= '0;
    end else if (strobes.countClear) begin
      runCount <= '0;
    end else if (strobes.countUp && (runCount != LAST)) begin
      runCount <= runCount + 1'b1;
    end
  end

  // The next qualifying sample completes the run
  assign runFull = (runCount == LAST);

endmodule

// File: rtl/mode_sequencer.sv
module mode_sequencer
  import buck_mode_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sampleStrobe,
  input  logic       phaseHigh,
  input  logic       underVolt,
  input  logic       runFull,
  output runStrobe_t strobes,
  output opMode_e    modeQ,
  output logic       offPulse
);

  logic    inPwm;
  logic    qualify;
  logic    breakRun;
  logic    uvExit;
  logic    runDone;
  opMode_e modeNext;
  logic    offNext;

  assign inPwm    = (modeQ == MODE_PWM);
  // A high sample favours hysteretic mode and a low sample favours PWM
  assign qualify  = sampleStrobe && (phaseHigh == inPwm);
  assign breakRun = sampleStrobe && (phaseHigh != inPwm);
  // An undervoltage exit is only possible from hysteretic mode
  assign uvExit   = !inPwm && underVolt;
  assign runDone  = qualify && runFull;

  always_comb begin
    modeNext = modeQ;
    offNext  = 1'b0;
    if (uvExit) begin
      modeNext = MODE_PWM;
    end else if (runDone) begin
      if (inPwm) begin
        modeNext = MODE_HYST;
        offNext  = 1'b1;
      end else begin
        modeNext = MODE_PWM;
      end
    end
  end

  always_comb begin
    strobes.countClear = uvExit || runDone || breakRun;
    strobes.countUp    = qualify && !runFull && !uvExit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ    <= MODE_PWM;
      offPulse <= 1'b0;
    end else begin
      modeQ    <= modeNext;
      offPulse <= offNext;
    end
  end

endmodule

// File: rtl/buck_mode_ctrl.sv
module buck_mode_ctrl
  import buck_mode_pkg::*;
#(
  parameter int RUN_LEN = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic sampleStrobe,
  input  logic phaseHigh,
  input  logic underVolt,
  output logic hystMode,
  output logic bothOff
);

  localparam int CNT_W = $clog2(RUN_LEN);

  runStrobe_t        strobes;
  logic [CNT_W-1:0]  runCount;
  logic              runFull;
  opMode_e           modeQ;

  mode_sequencer u_seq (
    .clk          (clk),
    .rstN         (rstN),
    .sampleStrobe (sampleStrobe),
    .phaseHigh    (phaseHigh),
    .underVolt    (underVolt),
    .runFull      (runFull),
    .strobes      (strobes),
    .modeQ        (modeQ),
    .offPulse     (bothOff)
  );

  mode_run_counter #(.RUN_LEN(RUN_LEN)) u_cnt (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .runCount (runCount),
    .runFull  (runFull)
  );

  assign hystMode = (modeQ == MODE_HYST);

endmodule

// File: rtl/buck_mode_ctrl_checker.sv
module buck_mode_ctrl_checker #(
  parameter int RUN_LEN = 8
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       sampleStrobe,
  input logic                       phaseHigh,
  input logic                       underVolt,
  input logic                       hystMode,
  input logic                       bothOff,
  input logic [$clog2(RUN_LEN)-1:0] runCount
);

  // R1
  count_in_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    int'(runCount) < RUN_LEN);

  // R4
  opposite_breaks_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleStrobe && (phaseHigh == hystMode) |=> runCount == '0);

  // R5
  idle_holds_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    !sampleStrobe && !(hystMode && underVolt) |=> $stable(hystMode) && $stable(runCount));

  // R6
  entry_raises_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hystMode) |-> bothOff);

  // R6
  off_only_on_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    bothOff |-> $rose(hystMode));

  // R7
  uv_exit_next_chk: assert property (@(posedge clk) disable iff (!rstN)
    hystMode && underVolt |=> !hystMode && !bothOff);

  // R9
  change_clears_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    hystMode != $past(hystMode) |-> runCount == '0);

endmodule

bind buck_mode_ctrl buck_mode_ctrl_checker #(.RUN_LEN(RUN_LEN)) u_chk (.*);

// File: tb/buck_mode_ctrl_test.sv
`timescale 1ns/1ps
module buck_mode_ctrl_test;

  localparam int RUN = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleStrobe = 1'b0;
  logic phaseHigh = 1'b0;
  logic underVolt = 1'b0;
  logic hystMode;
  logic bothOff;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // Expected outputs after the next rising edge
  logic  expHyst[$];
  logic  expOff[$];
  string expTag[$];

  // Reference model state
  int mCount = 0;
  bit mHyst = 1'b0;

  always #10 clk = ~clk;

  buck_mode_ctrl #(.RUN_LEN(RUN)) uut (
    .clk          (clk),
    .rstN         (rstN),
    .sampleStrobe (sampleStrobe),
    .phaseHigh    (phaseHigh),
    .underVolt    (underVolt),
    .hystMode     (hystMode),
    .bothOff      (bothOff)
  );

  task automatic check(input string tag, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Drive one cycle and push what the outputs must read after the edge
  task automatic cyc(input bit s, input bit p, input bit u, input string tag);
    bit off;
    bit qual;
    @(negedge clk);
    sampleStrobe = s;
    phaseHigh    = p;
    underVolt    = u;
    off = 1'b0;
    if (mHyst && u) begin
      mHyst  = 1'b0;
      mCount = 0;
    end else if (s) begin
      qual = mHyst ? !p : p;
      if (!qual) begin
        mCount = 0;
      end else if (mCount == RUN - 1) begin
        off    = !mHyst;
        mHyst  = !mHyst;
        mCount = 0;
      end else begin
        mCount++;
      end
    end
    expHyst.push_back(mHyst);
    expOff.push_back(off);
    expTag.push_back(tag);
  endtask

  // A strobed sample followed by an idle cycle whose phase value is misleading
  task automatic samp(input bit p, input bit u, input string tag);
    cyc(1'b1, p, u, tag);
    cyc(1'b0, !p, 1'b0, "R5");
  endtask

  task automatic run(input int n, input bit p, input string tag);
    for (int i = 0; i < n; i++) samp(p, 1'b0, tag);
  endtask

  // Monitor: compare after each edge
  always @(posedge clk) begin
    #2;
    if (expHyst.size() > 0) begin
      string t;
      t = expTag.pop_front();
      check(t, hystMode, expHyst.pop_front(), "hystMode");
      check(t, bothOff, expOff.pop_front(), "bothOff");
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", hystMode, 1'b0, "hystMode in reset");
    check("R1", bothOff, 1'b0, "bothOff in reset");
    rstN = 1'b1;
    @(negedge clk);
    check("R1", hystMode, 1'b0, "hystMode after reset");

    // R4 in PWM: broken run, then full run
    run(6, 1'b1, "R4");
    samp(1'b0, 1'b0, "R4");
    run(RUN - 1, 1'b1, "R2");
    samp(1'b1, 1'b0, "R2");          // eighth: enter hysteretic, R6 pulse
    cyc(1'b0, 1'b1, 1'b0, "R6");

    // R3 with a break in hysteretic mode
    run(5, 1'b0, "R4");
    samp(1'b1, 1'b0, "R4");
    run(RUN - 1, 1'b0, "R3");
    samp(1'b0, 1'b0, "R3");          // exit, no off pulse (R6)

    // R8: undervoltage held high through a PWM run
    for (int i = 0; i < RUN; i++) samp(1'b1, 1'b1, "R8");
    cyc(1'b0, 1'b0, 1'b0, "R6");

    // R7 without strobe, then R9 partial run discarded
    run(3, 1'b0, "R7");
    cyc(1'b0, 1'b0, 1'b1, "R7");
    run(5, 1'b1, "R9");
    run(3, 1'b1, "R9");
    cyc(1'b0, 1'b0, 1'b0, "R6");

    // R7 with a strobed high sample
    samp(1'b1, 1'b1, "R7");
    run(RUN, 1'b1, "R9");

    // R10: undervoltage with the completing sample
    run(RUN - 1, 1'b0, "R10");
    samp(1'b0, 1'b1, "R10");
    run(RUN - 1, 1'b1, "R10");
    samp(1'b1, 1'b0, "R10");
    cyc(1'b0, 1'b0, 1'b0, "R6");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog all actual=timeout expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule